// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a translation by reading a hierarchical page table from memory. A request gives a 32-bit virtual address and the page number of the top-level table. The upper twenty address bits form the virtual page number, which is cut into two 10-bit indices. The low twelve bits are the page offset and pass through unchanged. The walker reads one 32-bit entry per level over a simple request/response memory port. A valid entry at the top level gives the page number of the next table. A valid entry at the last level gives the physical page.

In an entry, bit 0 is the valid flag and bits 31:12 hold a page number. Bits 11:1 carry flag bits that the walker passes through. When an entry is invalid, everything beneath it is unmapped, so the walk stops at once and reports a fault. After the final response, the walker pulses `done` for one cycle and holds the physical address, the fault flag and the raw entry until the next result.

Top module: `ptw_walker`

## Requirements
- R1: During and after reset, `req_ready` is 1, and `done` and `mem_req_valid` are 0.
- R2: A request is accepted only while the walker is idle (`req_ready` high). While a walk is in progress, `req_valid` and `req_vaddr` have no effect on the reads issued or on the result.
- R3: The first read address is `{req_root_ppn, 12'h000} + vaddr[31:22]*4`.
- R4: After a valid top-level entry E, the second read address is `{E[31:12], 12'h000} + vaddr[21:12]*4`.
- R5: At most one read is outstanding. `mem_req_valid` is low from the accepting handshake until that read's response. While a request is stalled by `mem_req_ready` low, `mem_req_addr` stays stable.
- R6: If the top-level entry has bit 0 clear, the walk ends after exactly one read with `fault`=1, `paddr`=0 and `pte` equal to that entry.
- R7: If the last-level entry has bit 0 clear, the walk ends after two reads with `fault`=1, `paddr`=0 and `pte` equal to that entry.
- R8: If the last-level entry L is valid, `fault`=0, `paddr`=`{L[31:12], vaddr[11:0]}` and `pte`=L.
- R9: `done` is high for exactly one cycle per walk. `paddr`, `fault` and `pte` change only in a cycle where `done` is high.
- R10: `done` rises in the cycle right after the clock edge that accepts the final response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root_ppn | input | 20 | Page number of the top-level table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Walk hit an invalid entry |
| paddr | output | 32 | Physical address (0 on fault) |
| pte | output | 32 | Last entry read |

## Verification
Several internal faults show up at the ports. A wrong level counter or a wrong index slice shows up on `mem_req_addr` in the very next read. A base register that is not reloaded from the top-level entry corrupts the second address within one response. A valid check that skips early termination produces an extra read, which the bench sees one cycle after the invalid response. A state machine that fails to leave its result state shows a `done` pulse longer than one cycle. A walker that takes a request while busy shows unexpected reads or a result for the wrong address. The sweep covers every top-level index, both with and without memory stalls.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    parameter int LEVELS = 2;
    parameter int IDX_W  = 10;
    parameter int OFF_W  = 12;
    parameter int PTE_W  = 32;

    localparam int VA_W        = LEVELS * IDX_W + OFF_W;
    localparam int PPN_W       = PTE_W - OFF_W;
    localparam int FLAG_W      = OFF_W - 1;
    localparam int LVL_W       = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);

    typedef enum logic [1:0] {
        W_IDLE,
        W_ISSUE,
        W_WAIT,
        W_DONE
    } walk_state_e;

    typedef struct packed {
        logic [PPN_W-1:0]  ppn;
        logic [FLAG_W-1:0] flags;
        logic              valid;
    } pte_t;

    function automatic logic [PTE_W-1:0] entry_addr(
        input logic [PPN_W-1:0] base,
        input logic [IDX_W-1:0] idx
    );
        entry_addr = {base, {OFF_W{1'b0}}} + (PTE_W'(idx) << ENTRY_SHIFT);
    endfunction
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] field [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_field
        assign field[g] = vaddr[VA_W-1-g*IDX_W -: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int k = 0; k < LEVELS; k++) begin
            if (level == LVL_W'(k)) idx = field[k];
        end
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PPN_W-1:0] req_root_ppn,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic [VA_W-1:0]  vaddr_q,
    output logic [LVL_W-1:0] level_q,
    output logic [PPN_W-1:0] base_q,
    output logic             done,
    output logic             fault,
    output logic [PTE_W-1:0] paddr,
    output logic [PTE_W-1:0] pte
);
    walk_state_e state_q;
    pte_t        rsp_e;
    logic        last_level;

    assign rsp_e         = pte_t'(mem_rsp_data);
    assign last_level    = (level_q == LVL_W'(LEVELS - 1));
    assign req_ready     = (state_q == W_IDLE);
    assign mem_req_valid = (state_q == W_ISSUE);
    assign done          = (state_q == W_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= W_IDLE;
            vaddr_q <= '0;
            level_q <= '0;
            base_q  <= '0;
            fault   <= 1'b0;
            paddr   <= '0;
            pte     <= '0;
        end else begin
            unique case (state_q)
                W_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        base_q  <= req_root_ppn;
                        level_q <= '0;
                        state_q <= W_ISSUE;
                    end
                end
                W_ISSUE: begin
                    if (mem_req_ready) state_q <= W_WAIT;
                end
                W_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!rsp_e.valid) begin
                            fault   <= 1'b1;
                            paddr   <= '0;
                            pte     <= mem_rsp_data;
                            state_q <= W_DONE;
                        end else if (last_level) begin
                            fault   <= 1'b0;
                            paddr   <= {rsp_e.ppn, vaddr_q[OFF_W-1:0]};
                            pte     <= mem_rsp_data;
                            state_q <= W_DONE;
                        end else begin
                            base_q  <= rsp_e.ppn;
                            level_q <= level_q + 1'b1;
                            state_q <= W_ISSUE;
                        end
                    end
                end
                W_DONE: state_q <= W_IDLE;
                default: state_q <= W_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PPN_W-1:0] req_root_ppn,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PTE_W-1:0] mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             done,
    output logic             fault,
    output logic [PTE_W-1:0] paddr,
    output logic [PTE_W-1:0] pte
);
    logic [VA_W-1:0]  vaddr_q;
    logic [LVL_W-1:0] level_q;
    logic [PPN_W-1:0] base_q;
    logic [IDX_W-1:0] cur_idx;

    ptw_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_vaddr    (req_vaddr),
        .req_root_ppn (req_root_ppn),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .vaddr_q      (vaddr_q),
        .level_q      (level_q),
        .base_q       (base_q),
        .done         (done),
        .fault        (fault),
        .paddr        (paddr),
        .pte          (pte)
    );

    ptw_index_sel u_idx (
        .vaddr(vaddr_q),
        .level(level_q),
        .idx  (cur_idx)
    );

    assign mem_req_addr = entry_addr(base_q, cur_idx);
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
    import ptw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic [PPN_W-1:0] req_root_ppn,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PTE_W-1:0] mem_req_addr,
    input logic             mem_rsp_valid,
    input logic [PTE_W-1:0] mem_rsp_data,
    input logic             done,
    input logic             fault,
    input logic [PTE_W-1:0] paddr,
    input logic [PTE_W-1:0] pte
);
    logic outstanding;

    always_ff @(posedge clk) begin
        if (rst) outstanding <= 1'b0;
        else if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
        else if (mem_rsp_valid) outstanding <= 1'b0;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> req_ready && !done && !mem_req_valid); // R1
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready); // R2
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        outstanding |-> !mem_req_valid); // R5
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R5
    AST_FAULT_ZERO_PADDR: assert property (@(posedge clk) disable iff (rst)
        done && fault |-> paddr == '0); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(paddr) && $stable(fault) && $stable(pte)); // R9
    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_rsp_valid)); // R10
endmodule

bind ptw_walker ptw_walker_chk u_chk (.*);

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
    localparam logic [19:0] ROOT_PG = 20'h00100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [19:0] req_root_ppn = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done, fault;
    logic [31:0] paddr, pte;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int nreads = 0;
    int rsp_at = 0;
    int overlap_err = 0;
    logic [31:0] rd_addr [4];
    logic        rsp_pend = 1'b0;
    logic [31:0] pend_addr = '0;
    logic        stall_on = 1'b0;

    always #4 clk = ~clk;

    ptw_walker dut (.*);

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [19:0] pg;
        logic [9:0]  ix;
        logic [19:0] nb;
        pg = a[31:12];
        ix = a[11:2];
        if (pg == ROOT_PG) begin
            nb = 20'h00200 + 20'(ix);
            mem_word = {nb, 11'(ix * 3), ((ix % 5) != 3)};
        end else begin
            nb = (pg << 10) ^ 20'(ix * 7);
            mem_word = {nb, 11'(ix), (((32'(pg) + 32'(ix)) % 7) != 0)};
        end
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // memory model, driven away from the active edge
    always @(negedge clk) begin
        if (rsp_pend && mem_req_valid) overlap_err++;
        if (rsp_pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem_word(pend_addr);
            rsp_pend      = 1'b0;
            rsp_at        = cyc;
        end else begin
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = 32'hDEAD_BEEF;
        end
        mem_req_ready = stall_on ? (cyc[0] ^ cyc[2]) : 1'b1;
        if (mem_req_valid && mem_req_ready && !rst) begin
            if (nreads < 4) rd_addr[nreads] = mem_req_addr;
            nreads++;
            rsp_pend  = 1'b1;
            pend_addr = mem_req_addr;
        end
    end

    task automatic walk(input logic [31:0] va, input bit junk);
        logic [31:0] top, leaf, exp_pte, exp_pa, held;
        int exp_reads, wait_n;
        bit exp_fault;
        top = mem_word({ROOT_PG, va[31:22], 2'b00});
        leaf = mem_word({top[31:12], va[21:12], 2'b00});
        if (!top[0]) begin
            exp_reads = 1; exp_fault = 1; exp_pte = top; exp_pa = 0;
        end else if (!leaf[0]) begin
            exp_reads = 2; exp_fault = 1; exp_pte = leaf; exp_pa = 0;
        end else begin
            exp_reads = 2; exp_fault = 0; exp_pte = leaf; exp_pa = {leaf[31:12], va[11:0]};
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        nreads       = 0;
        overlap_err  = 0;
        req_valid    = 1'b1;
        req_vaddr    = va;
        req_root_ppn = ROOT_PG;
        @(negedge clk);
        if (junk) begin
            req_vaddr    = ~va;             // R2: ignored while busy
            req_root_ppn = 20'h00AAA;
        end else begin
            req_valid = 1'b0;
        end
        chk(!req_ready, "R2 busy after accept", 32'(req_ready), 0);
        wait_n = 0;
        while (!done && wait_n < 200) begin
            @(negedge clk);
            wait_n++;
        end
        req_valid = 1'b0;
        chk(done, "R10 walk completes", 32'(done), 1);
        chk(cyc == rsp_at + 1, "R10 done latency", 32'(cyc - rsp_at), 1);
        chk(nreads == exp_reads, exp_fault && exp_reads == 1 ? "R6 read count" : "R7 read count",
            32'(nreads), 32'(exp_reads));
        chk(rd_addr[0] == {ROOT_PG, 12'h000} + {20'h0, va[31:22], 2'b00}, "R3 top address",
            rd_addr[0], {ROOT_PG, 12'h000} + {20'h0, va[31:22], 2'b00});
        if (exp_reads == 2)
            chk(rd_addr[1] == {top[31:12], 12'h000} + {20'h0, va[21:12], 2'b00}, "R4 leaf address",
                rd_addr[1], {top[31:12], 12'h000} + {20'h0, va[21:12], 2'b00});
        chk(overlap_err == 0, "R5 single outstanding", 32'(overlap_err), 0);
        chk(fault == exp_fault, exp_fault ? "R6 R7 fault flag" : "R8 fault flag", 32'(fault), 32'(exp_fault));
        chk(paddr == exp_pa, exp_fault ? "R6 R7 paddr zero" : "R8 paddr", paddr, exp_pa);
        chk(pte == exp_pte, exp_fault ? "R6 R7 pte" : "R8 pte", pte, exp_pte);
        held = paddr;
        @(negedge clk);
        chk(!done, "R9 done one cycle", 32'(done), 0);
        chk(paddr == held, "R9 result held", paddr, held);
        @(negedge clk);
        chk(nreads == exp_reads, "R2 no extra reads", 32'(nreads), 32'(exp_reads));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && !done && !mem_req_valid, "R1 reset state",
            {29'h0, req_ready, done, mem_req_valid}, 32'h4);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !done && !mem_req_valid, "R1 after reset",
            {29'h0, req_ready, done, mem_req_valid}, 32'h4);
        for (int i = 0; i < 1024; i++) begin
            for (int k = 0; k < 2; k++) begin
                logic [9:0]  j;
                logic [11:0] off;
                j   = 10'((i * 37 + k * 511 + 5) & 1023);
                off = 12'((i * 13 + k * 2049) & 12'hFFF);
                stall_on = (k == 1);
                walk({10'(i), j, off}, (i % 4) == 0);
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule